// File: doc/BRIEF.md
# Keyed Diagnostic Register Guard

This block protects a diagnostic control register on a 32-bit host write bus. The register stays locked until the host writes a fixed five-word key to a key register in the right order. Once the key is complete, the host may write the diagnostic register. In that register, one bit starts a soft reset pulse of fixed length and another bit turns on a diagnostic memory map. While the map is on, the block flags each host access in the memory window above a protected low area as one to be redirected to local addresses. The processor and the redirected memory are outside this block; the block only produces the qualifier.

The same bus also reaches an inbound doorbell and an interrupt enable. The host can only set doorbell bits. The local side clears them through a write-one-to-clear input. An interrupt line goes high while any doorbell bit is set and the doorbell interrupt is enabled.

The guard is a state machine with seven states. ST_IDLE is locked with no key progress. ST_K1 to ST_K4 record how many key words have matched. ST_OPEN means unlocked. ST_PULSE means a soft reset is running.

Its transitions are as follows:
- **advance**: a matching key word moves one state forward.
- **complete**: the fifth matching word moves ST_K4 to ST_OPEN.
- **mismatch**: a wrong key word moves to ST_IDLE.
- **relock**: any key write in ST_OPEN moves to ST_IDLE.
- **fire**: a diagnostic write with the reset bit set moves ST_OPEN to ST_PULSE.
- **expire**: the last pulse cycle moves ST_PULSE to ST_IDLE.

Top module: `diag_unlock_ctl`

## Requirements
- R1: After reset, unlocked, soft_rst, map_on, irq and doorbell are all 0, and acc_remap is 0.
- R2: Writes of 0x4, 0xB, 0x2, 0x7, 0xD, in that order, to key address 0x04 set unlocked in the cycle after the fifth write. Writes to other addresses between key words do not disturb the progress.
- R3: A key write whose value does not match the next expected word drops all progress, and the full five-word key is needed again.
- R4: While locked, writes to diagnostic address 0x08 have no effect: map_on and soft_rst stay 0.
- R5: Any write to the key address while unlocked clears unlocked. Later diagnostic writes are then ignored.
- R6: Diagnostic address 0x08 has two bits. Bit 0 is the reset bit and bit 1 is the map enable. While unlocked, writing bit 1 sets map_on to that value. Writing bit 0 as 1 raises soft_rst in the next cycle for exactly 16 cycles. In that same cycle map_on clears and the guard relocks.
- R7: While soft_rst is high, host writes are ignored, and the doorbell and the interrupt enable are cleared.
- R8: acc_remap is 1 exactly when map_on, acc_valid and acc_off >= 0x80 are all true.
- R9: A host write to doorbell address 0x20 ORs its data into the doorbell. It never clears a bit.
- R10: Each 1 in db_clr clears that doorbell bit in the next cycle. If a host set hits the same bit in the same cycle, the set wins.
- R11: Bit 0 of a write to address 0x30 is the doorbell interrupt enable. irq is 1 exactly when that enable is 1 and the doorbell is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host register address |
| wr_data | input | 32 | Host write data |
| db_clr | input | 32 | Local write-one-to-clear mask for the doorbell |
| acc_valid | input | 1 | A host access to the memory window is present |
| acc_off | input | 20 | Offset of that access within the window |
| unlocked | output | 1 | Diagnostic register accepts writes |
| soft_rst | output | 1 | Soft reset pulse |
| map_on | output | 1 | Diagnostic memory map enabled |
| acc_remap | output | 1 | Current access is to be redirected |
| doorbell | output | 32 | Inbound doorbell bits |
| irq | output | 1 | Doorbell interrupt |

## Verification
The hardest state to reach is the soft reset pulse. It first needs the full key with no slip, and then a diagnostic write with the reset bit set. The stimulus builds that path with directed writes. Partway through the pulse it adds a doorbell write, to show that host writes are dropped during the pulse. Before that, a broken key that ends in the right tail words shows that a mismatch really returns to the start. The doorbell set/clear races come from seeded random masks that are checked against a bench model.

// File: rtl/diag_unlock_pkg.sv
package diag_unlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_K1    = 3'd1,
        ST_K2    = 3'd2,
        ST_K3    = 3'd3,
        ST_K4    = 3'd4,
        ST_OPEN  = 3'd5,
        ST_PULSE = 3'd6
    } ustate_t;

    localparam int KEY_LEN = 5;

    // Expected key word for a given progress index
    function automatic logic [31:0] key_word(input logic [2:0] idx);
        case (idx)
            3'd0:    key_word = 32'h4;
            3'd1:    key_word = 32'hB;
            3'd2:    key_word = 32'h2;
            3'd3:    key_word = 32'h7;
            default: key_word = 32'hD;
        endcase
    endfunction

endpackage

// File: rtl/diag_key_fsm.sv
module diag_key_fsm
    import diag_unlock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        diag_wr,
    input  logic        diag_rst_bit,
    input  logic        pulse_last,
    output logic        unlocked,
    output logic        pulsing,
    output logic        fire
);

    ustate_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4: begin
                if (key_wr) begin
                    if (key_data == key_word(state))
                        state_nx = (state == ST_K4) ? ST_OPEN
                                                    : ustate_t'(state + 3'd1);
                    else
                        state_nx = ST_IDLE;
                end
            end
            ST_OPEN: begin
                if (key_wr)
                    state_nx = ST_IDLE;
                else if (diag_wr && diag_rst_bit)
                    state_nx = ST_PULSE;
            end
            ST_PULSE: begin
                if (pulse_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        unlocked = (state == ST_OPEN);
        pulsing  = (state == ST_PULSE);
        fire     = (state == ST_OPEN) && diag_wr && diag_rst_bit && !key_wr;
    end

endmodule

// File: rtl/diag_pulse_timer.sv
module diag_pulse_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic last
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(LEN - 1);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = run && (cnt == '0);

endmodule

// File: rtl/diag_doorbell.sv
module diag_doorbell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         set_en,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] loc_clr,
    output logic [W-1:0] bits
);

    logic [W-1:0] set_mask;

    assign set_mask = set_en ? set_bits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all)
            bits <= '0;
        else
            bits <= (bits & ~loc_clr) | set_mask;
    end

endmodule

// File: rtl/diag_unlock_ctl.sv
module diag_unlock_ctl #(
    parameter int          AW          = 8,
    parameter int          DW          = 32,
    parameter int          OFF_W       = 20,
    parameter int          PULSE_LEN   = 16,
    parameter logic [7:0]  ADR_KEY     = 8'h04,
    parameter logic [7:0]  ADR_DIAG    = 8'h08,
    parameter logic [7:0]  ADR_BELL    = 8'h20,
    parameter logic [7:0]  ADR_IRQEN   = 8'h30,
    parameter int          REMAP_FLOOR = 'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    db_clr,
    input  logic             acc_valid,
    input  logic [OFF_W-1:0] acc_off,
    output logic             unlocked,
    output logic             soft_rst,
    output logic             map_on,
    output logic             acc_remap,
    output logic [DW-1:0]    doorbell,
    output logic             irq
);

    localparam logic [OFF_W-1:0] FLOOR = OFF_W'(REMAP_FLOOR);

    logic wr_ok, key_wr, diag_wr, bell_wr, en_wr;
    logic fire, pulse_last, irq_en;

    // Host writes are dropped while the soft reset pulse runs
    assign wr_ok   = wr_en && !soft_rst;
    assign key_wr  = wr_ok && (wr_addr == AW'(ADR_KEY));
    assign diag_wr = wr_ok && (wr_addr == AW'(ADR_DIAG));
    assign bell_wr = wr_ok && (wr_addr == AW'(ADR_BELL));
    assign en_wr   = wr_ok && (wr_addr == AW'(ADR_IRQEN));

    diag_key_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_data    (32'(wr_data)),
        .diag_wr     (diag_wr),
        .diag_rst_bit(wr_data[0]),
        .pulse_last  (pulse_last),
        .unlocked    (unlocked),
        .pulsing     (soft_rst),
        .fire        (fire)
    );

    diag_pulse_timer #(.LEN(PULSE_LEN)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(fire),
        .run  (soft_rst),
        .last (pulse_last)
    );

    diag_doorbell #(.W(DW)) u_bell (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (soft_rst),
        .set_en  (bell_wr),
        .set_bits(wr_data),
        .loc_clr (db_clr),
        .bits    (doorbell)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || fire)
            map_on <= 1'b0;
        else if (diag_wr && unlocked)
            map_on <= wr_data[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            irq_en <= 1'b0;
        else if (en_wr)
            irq_en <= wr_data[0];
    end

    assign irq       = irq_en && (doorbell != '0);
    assign acc_remap = map_on && acc_valid && (acc_off >= FLOOR);

endmodule

// File: rtl/diag_unlock_chk.sv
module diag_unlock_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [7:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] db_clr,
    input logic        acc_valid,
    input logic [19:0] acc_off,
    input logic        unlocked,
    input logic        soft_rst,
    input logic        map_on,
    input logic        acc_remap,
    input logic [31:0] doorbell,
    input logic        irq
);

    logic [5:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (soft_rst) run_len <= run_len + 6'd1;
        else               run_len <= '0;
    end

    a_r2_unlock_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(wr_en && wr_addr == 8'h04 && wr_data == 32'hD));

    a_r4_map_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_on) |-> $past(unlocked));

    a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> run_len < 6'd16);

    a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> run_len == 6'd16);

    a_r6_map_off_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> !map_on && !unlocked);

    a_r8_low_area_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_off < 20'h80) |-> !acc_remap);

    a_r9_bits_only_drop_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(soft_rst) |-> ((($past(doorbell) & ~doorbell) & ~$past(db_clr)) == 32'h0));

    a_r11_irq_needs_bell: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> doorbell != 32'h0);

endmodule

bind diag_unlock_ctl diag_unlock_chk u_chk (.*);

// File: tb/sim_diag_unlock_ctl.sv
`timescale 1ns/1ps
module sim_diag_unlock_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] db_clr = '0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_off = '0;
    logic        unlocked, soft_rst, map_on, acc_remap, irq;
    logic [31:0] doorbell;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    diag_unlock_ctl u0 (.*);

    function automatic logic [31:0] bell_model(input logic [31:0] cur,
                                               input logic [31:0] set,
                                               input logic [31:0] clr);
        return (cur & ~clr) | set;
    endfunction

    function automatic logic remap_model(input logic m, input logic v,
                                         input logic [19:0] off);
        return m && v && (off >= 20'h80);
    endfunction

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_key();
        wr(8'h04, 32'h4); wr(8'h04, 32'hB); wr(8'h04, 32'h2);
        wr(8'h04, 32'h7); wr(8'h04, 32'hD);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_db;
        int n;
        void'($urandom(32'h5eed_0011));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 unlocked", unlocked, 0);
        check("R1 soft_rst", soft_rst, 0);
        check("R1 map_on", map_on, 0);
        check("R1 doorbell", doorbell, 0);
        check("R1 irq", irq, 0);

        // R4 locked diag write ignored
        wr(8'h08, 32'h3);
        check("R4 map_on", map_on, 0);
        check("R4 soft_rst", soft_rst, 0);

        // R2 partial key, other writes interleaved
        wr(8'h04, 32'h4); wr(8'h04, 32'hB); wr(8'h30, 32'h0);
        wr(8'h04, 32'h2); wr(8'h04, 32'h7);
        check("R2 not yet", unlocked, 0);
        wr(8'h04, 32'hD);
        check("R2 unlocked", unlocked, 1);

        // R5 relock, then diag ignored
        wr(8'h04, 32'h4);
        check("R5 relock", unlocked, 0);
        wr(8'h08, 32'h2);
        check("R5 diag ignored", map_on, 0);

        // R3 broken key then tail
        wr(8'h04, 32'h4); wr(8'h04, 32'hB); wr(8'h04, 32'h9);
        wr(8'h04, 32'h2); wr(8'h04, 32'h7); wr(8'h04, 32'hD);
        check("R3 stays locked", unlocked, 0);
        send_key();
        check("R3 full key", unlocked, 1);

        // R8 map and remap qualifier
        wr(8'h08, 32'h2);
        check("R6 map set", map_on, 1);
        foreach (acc_off[i]) begin end
        for (int k = 0; k < 6; k++) begin
            acc_valid = (k != 5);
            acc_off = (k == 0) ? 20'h7F : (k == 1) ? 20'h80 : (k == 2) ? 20'h0 :
                      20'($urandom);
            #1;
            check("R8 remap", acc_remap, remap_model(map_on, acc_valid, acc_off));
        end
        acc_valid = 1'b0;

        // R9 R10 R11 doorbell random
        wr(8'h30, 32'h1);
        exp_db = '0;
        for (int k = 0; k < 200; k++) begin
            logic [31:0] s, c;
            logic        we;
            we = ($urandom % 2) == 0;
            s  = $urandom & $urandom;
            c  = (k % 7 == 0) ? 32'hFFFF_FFFF : ($urandom & $urandom);
            @(negedge clk);
            wr_en = we; wr_addr = 8'h20; wr_data = s; db_clr = c;
            exp_db = bell_model(exp_db, we ? s : 32'h0, c);
            @(negedge clk);
            wr_en = 1'b0; db_clr = '0;
            check("R9 R10 doorbell", doorbell, exp_db);
            check("R11 irq", irq, exp_db != 0);
        end
        // R10 same-bit race: set wins
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'h1; db_clr = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0; db_clr = '0;
        check("R10 set wins", doorbell, 32'h1);

        // R6 R7 soft reset pulse
        wr(8'h08, 32'h3);
        check("R6 pulse starts", soft_rst, 1);
        check("R6 map cleared", map_on, 0);
        check("R6 relocked", unlocked, 0);
        n = 0;
        while (soft_rst && n < 40) begin
            if (n == 3) begin wr_en = 1'b1; wr_addr = 8'h20; wr_data = 32'hF0; end
            if (n == 4) wr_en = 1'b0;
            n++;
            @(negedge clk);
        end
        check("R6 pulse length", n, 16);
        check("R7 doorbell cleared", doorbell, 0);
        wr(8'h20, 32'h8);
        check("R7 doorbell after", doorbell, 32'h8);
        check("R7 enable cleared", irq, 0);
        check("R6 locked after", unlocked, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule